// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs management transactions on a two-wire serial management bus towards an Ethernet PHY. It derives the management clock from the system clock through a half-period counter. It drives the bidirectional data line through three separate signals: a data output, an output enable and a data input. The pad itself sits outside the block.

A transaction starts with a one-cycle `start_i` pulse while the block is idle. That pulse supplies a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then sends a frame in this order:

- 32 bits of ones as a preamble.
- The start and opcode bits.
- Both addresses.
- The turnaround.
- The 16 data bits, after which the line is released for a few clock cycles.

On a read, the block listens for the PHY to pull the turnaround low. If no PHY answers, the block clocks 32 recovery cycles with the line released. It then reports an error together with all-ones read data. Completion is marked by a one-cycle `done_o` pulse.

Top module: `mdio_frame_master`

## Requirements
- R1: While idle, `mdc_o` is high, `mdio_oe_o` is low and `busy_o` is low. A `start_i` seen while idle is accepted, and `busy_o` is high from the next cycle until completion.
- R2: MDC low and high phases each last exactly `HALF_PERIOD` system clock cycles. The first low phase begins in the cycle after the start is accepted. A bit slot is one low phase followed by one high phase.
- R3: Every frame opens with 32 slots in which the master drives 1.
- R4: After the preamble the master drives these slots in order: the start bits 0 then 1, the opcode (1,0 for a read, 0,1 for a write), the PHY address with bit 4 first, and then the register address with bit 4 first.
- R5: The master changes `mdio_o` and `mdio_oe_o` only in the cycle in which `mdc_o` falls, so driven values stay stable through each high phase.
- R6: On a read, the slot after the register address is released (`mdio_oe_o` low). `mdio_i` is sampled in the last cycle of that slot's high phase, and a 0 there means a PHY is present.
- R7: If that turnaround sample is 1, the master runs 32 more released slots and then completes with `err_o`=1 and `rd_data_o`=16'hFFFF.
- R8: On a read with a PHY present, the master runs 16 released data slots. Each sample is taken in the last cycle of the high phase and the first sample is bit 15. Then come 2 more released slots, and the master completes with `err_o`=0 and the sampled word on `rd_data_o`.
- R9: On a write, the master drives a turnaround of 1 then 0, followed by the 16 data bits with bit 15 first. It then releases the line for one final slot and completes with `err_o`=0, leaving `rd_data_o` unchanged.
- R10: `done_o` is high for exactly one cycle: the cycle after the final high phase ends. In that cycle `busy_o` is low and `mdc_o` stays high.
- R11: A `start_i` pulse that arrives while `busy_o` is high has no effect on the frame in progress, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Data for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last read found no PHY (valid with done) |
| rd_data_o | output | 16 | Last read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench aims at two areas:

- **Opcode and turnaround.** It runs reads and writes with both address extremes and compares the predicted clock phase, the enable and the driven bit on every cycle. A swapped opcode, a wrong turnaround on a write or a dropped preamble slot would shift or corrupt that pattern within a few cycles.
- **Missing PHY.** A design that skipped the check would return the floating line as data with no error. A design with a wrong recovery length would finish early or late, so its done pulse would miss the predicted cycle.

Further cases are:

- **Sampling and bit order.** Read words with alternating and edge bit patterns catch sampling in the wrong phase or the wrong bit order.
- **Stray start.** A start pulse injected in the middle of a frame would, in a design that did not ignore it, restart or reopen the frame. That shows up as a waveform mismatch or as activity after done.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;

    localparam int ADDR_W        = 5;
    localparam int DATA_W        = 16;
    localparam int PRE_SLOTS     = 32;
    localparam int RECOVER_SLOTS = 32;
    localparam int RD_TAIL_SLOTS = 2;
    localparam int HDR_BITS      = 4 + 2 * ADDR_W;
    localparam int WR_BITS       = 2 + DATA_W;
    localparam int CNT_W         = $clog2(PRE_SLOTS) + 1;
    localparam logic [DATA_W-1:0] NO_PHY_WORD = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_RD_TA,
        ST_RD_DATA,
        ST_RD_TAIL,
        ST_RD_RECOVER,
        ST_WR_BODY,
        ST_WR_TAIL
    } seq_state_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;

    // start pattern, opcode, PHY address, register address; sent MSB first
    function automatic logic [HDR_BITS-1:0] frame_header(input mgmt_cmd_t c);
        logic [1:0] op;
        op = c.rd ? 2'b10 : 2'b01;
        return {2'b01, op, c.phy, c.regad};
    endfunction

    // write turnaround followed by the data word
    function automatic logic [WR_BITS-1:0] write_body(input mgmt_cmd_t c);
        return {2'b10, c.wdata};
    endfunction

endpackage

// File: rtl/mdc_half_timer.sv
module mdc_half_timer #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    input  logic active_i,
    input  logic last_i,
    output logic mdc_o,
    output logic slot_end_o
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          half_end;

    assign half_end   = active_i && (cnt_q == CNT_LAST);
    assign slot_end_o = half_end && mdc_q;
    assign mdc_o      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc_q <= 1'b1;
        end else if (launch_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            // after the final slot the clock parks high
            mdc_q <= !mdc_q || last_i;
        end else if (active_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  mgmt_cmd_t         cmd_i,
    input  logic              mdio_i,
    input  logic              slot_end_i,
    output logic              launch_o,
    output logic              busy_o,
    output logic              last_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rd_data_o
);
    seq_state_t          st_q;
    logic [CNT_W-1:0]    left_q;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [WR_BITS-1:0]  wr_sr;
    logic [DATA_W-1:0]   rd_sr;
    logic                is_rd_q;
    logic                left_zero;

    assign left_zero = (left_q == '0);
    assign launch_o  = start_i && (st_q == ST_IDLE);
    assign busy_o    = (st_q != ST_IDLE);
    assign last_o    = left_zero &&
                       ((st_q == ST_RD_TAIL) || (st_q == ST_RD_RECOVER) || (st_q == ST_WR_TAIL));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            left_q    <= '0;
            hdr_sr    <= '0;
            wr_sr     <= '0;
            rd_sr     <= '0;
            is_rd_q   <= 1'b0;
            mdio_o    <= 1'b1;
            mdio_oe_o <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            rd_data_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch_o) begin
                st_q      <= ST_PRE;
                left_q    <= CNT_W'(PRE_SLOTS - 1);
                hdr_sr    <= frame_header(cmd_i);
                wr_sr     <= write_body(cmd_i);
                is_rd_q   <= cmd_i.rd;
                mdio_o    <= 1'b1;
                mdio_oe_o <= 1'b1;
            end else if (slot_end_i) begin
                case (st_q)
                    ST_PRE: begin
                        if (left_zero) begin
                            st_q   <= ST_HDR;
                            left_q <= CNT_W'(HDR_BITS - 1);
                            mdio_o <= hdr_sr[HDR_BITS-1];
                            hdr_sr <= hdr_sr << 1;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                    ST_HDR: begin
                        if (left_zero) begin
                            if (is_rd_q) begin
                                st_q      <= ST_RD_TA;
                                left_q    <= '0;
                                mdio_oe_o <= 1'b0;
                            end else begin
                                st_q   <= ST_WR_BODY;
                                left_q <= CNT_W'(WR_BITS - 1);
                                mdio_o <= wr_sr[WR_BITS-1];
                                wr_sr  <= wr_sr << 1;
                            end
                        end else begin
                            left_q <= left_q - 1'b1;
                            mdio_o <= hdr_sr[HDR_BITS-1];
                            hdr_sr <= hdr_sr << 1;
                        end
                    end
                    ST_RD_TA: begin
                        if (mdio_i) begin
                            st_q   <= ST_RD_RECOVER;
                            left_q <= CNT_W'(RECOVER_SLOTS - 1);
                        end else begin
                            st_q   <= ST_RD_DATA;
                            left_q <= CNT_W'(DATA_W - 1);
                        end
                    end
                    ST_RD_DATA: begin
                        rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
                        if (left_zero) begin
                            st_q   <= ST_RD_TAIL;
                            left_q <= CNT_W'(RD_TAIL_SLOTS - 1);
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                    ST_RD_TAIL: begin
                        if (left_zero) begin
                            st_q      <= ST_IDLE;
                            done_o    <= 1'b1;
                            err_o     <= 1'b0;
                            rd_data_o <= rd_sr;
                            mdio_o    <= 1'b1;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                    ST_RD_RECOVER: begin
                        if (left_zero) begin
                            st_q      <= ST_IDLE;
                            done_o    <= 1'b1;
                            err_o     <= 1'b1;
                            rd_data_o <= NO_PHY_WORD;
                            mdio_o    <= 1'b1;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                    ST_WR_BODY: begin
                        if (left_zero) begin
                            st_q      <= ST_WR_TAIL;
                            left_q    <= '0;
                            mdio_oe_o <= 1'b0;
                        end else begin
                            left_q <= left_q - 1'b1;
                            mdio_o <= wr_sr[WR_BITS-1];
                            wr_sr  <= wr_sr << 1;
                        end
                    end
                    ST_WR_TAIL: begin
                        st_q   <= ST_IDLE;
                        done_o <= 1'b1;
                        err_o  <= 1'b0;
                        mdio_o <= 1'b1;
                    end
                    default: begin
                        st_q      <= ST_IDLE;
                        mdio_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_frame_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wr_data_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [15:0] rd_data_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    mgmt_cmd_t cmd;
    logic      launch;
    logic      last_slot;
    logic      slot_end;

    assign cmd = '{rd: rd_i, phy: phy_addr_i, regad: reg_addr_i, wdata: wr_data_i};

    mdc_half_timer #(.HALF_PERIOD(HALF_PERIOD)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .launch_i   (launch),
        .active_i   (busy_o),
        .last_i     (last_slot),
        .mdc_o      (mdc_o),
        .slot_end_o (slot_end)
    );

    mdio_frame_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmd_i      (cmd),
        .mdio_i     (mdio_i),
        .slot_end_i (slot_end),
        .launch_o   (launch),
        .busy_o     (busy_o),
        .last_o     (last_slot),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
    parameter int HALF_PERIOD = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [15:0] rd_data_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    logic        mdc_q;
    logic [15:0] run_len;

    // length of the MDC run that ended in the previous cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q   <= 1'b1;
            run_len <= '0;
        end else begin
            mdc_q <= mdc_o;
            if (mdc_o != mdc_q) run_len <= 16'd1;
            else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
        end
    end

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (mdc_o && !mdio_oe_o));

    a_r1_accept: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !mdc_o));

    a_r2_phase_len: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && (mdc_o != mdc_q)) |-> (run_len == 16'(HALF_PERIOD)));

    a_r2_last_phase_len: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_len == 16'(HALF_PERIOD)));

    a_r5_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ($fell(mdc_o) || ($stable(mdio_o) && $stable(mdio_oe_o))));

    a_r7_absent_word: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (rd_data_o == 16'hFFFF));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_done_end: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o) && mdc_o));

endmodule

bind mdio_frame_master mdio_frame_master_chk #(.HALF_PERIOD(HALF_PERIOD)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .rd_data_o (rd_data_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_frame_master_tb_top.sv
module mdio_frame_master_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mdio_i = 1'b1;
    logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] last_rd = 16'h0000;

    always #10 clk = ~clk;

    mdio_frame_master #(.HALF_PERIOD(HP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rd_data_o(rd_data_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit present,
                           input logic [15:0] pdata, input bit poke, input string name);
        bit e_oe[$];
        bit e_val[$];
        bit resp[$];
        int total;
        int bad;
        int first_k;
        int slot;
        bit exp_mdc;
        logic [15:0] exp_rd;
        bit exp_err;
        logic [31:0] bad_act;
        logic [31:0] bad_exp;

        // R3 preamble
        for (int i = 0; i < 32; i++) begin e_oe.push_back(1); e_val.push_back(1); end
        // R4 start, opcode, addresses
        e_oe.push_back(1); e_val.push_back(0);
        e_oe.push_back(1); e_val.push_back(1);
        e_oe.push_back(1); e_val.push_back(rd);
        e_oe.push_back(1); e_val.push_back(!rd);
        for (int i = 4; i >= 0; i--) begin e_oe.push_back(1); e_val.push_back(pa[i]); end
        for (int i = 4; i >= 0; i--) begin e_oe.push_back(1); e_val.push_back(ra[i]); end
        if (rd) begin
            // R6 released turnaround, then R8 data+tail or R7 recovery
            e_oe.push_back(0); e_val.push_back(0);
            for (int i = 0; i < (present ? 18 : 32); i++) begin e_oe.push_back(0); e_val.push_back(0); end
        end else begin
            // R9 write turnaround, data, release
            e_oe.push_back(1); e_val.push_back(1);
            e_oe.push_back(1); e_val.push_back(0);
            for (int i = 15; i >= 0; i--) begin e_oe.push_back(1); e_val.push_back(wd[i]); end
            e_oe.push_back(0); e_val.push_back(0);
        end
        for (int i = 0; i < e_oe.size(); i++) resp.push_back(1);
        if (rd && present) begin
            resp[46] = 0;
            for (int i = 0; i < 16; i++) resp[47 + i] = pdata[15 - i];
        end
        exp_rd  = rd ? (present ? pdata : 16'hFFFF) : last_rd;
        exp_err = rd && !present;
        total   = e_oe.size() * 2 * HP;
        bad     = 0;
        first_k = -1;
        bad_act = '0;
        bad_exp = '0;

        @(negedge clk);
        rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wr_data_i = wd; start_i = 1'b1;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            start_i = poke && (k == 40);
            if (poke && k == 40) begin
                rd_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wr_data_i = ~wd;
            end
            if (k < total) begin
                slot    = k / (2 * HP);
                mdio_i  = resp[slot];
                exp_mdc = (k % (2 * HP)) >= HP;
                if (mdc_o !== exp_mdc || busy_o !== 1'b1 || done_o !== 1'b0 ||
                    mdio_oe_o !== e_oe[slot] || (e_oe[slot] && mdio_o !== e_val[slot])) begin
                    if (bad == 0) begin
                        first_k = k;
                        bad_act = {26'd0, mdc_o, busy_o, done_o, mdio_oe_o, mdio_o, 1'b0};
                        bad_exp = {26'd0, exp_mdc, 1'b1, 1'b0, e_oe[slot], e_val[slot], 1'b0};
                    end
                    bad++;
                end
            end else begin
                mdio_i = 1'b1;
                chk(done_o === 1'b1, "R10", {name, " done pulse at end"}, 32'(done_o), 32'd1);
                chk(busy_o === 1'b0 && mdc_o === 1'b1 && mdio_oe_o === 1'b0, "R10",
                    {name, " idle lines at done"}, {29'd0, busy_o, mdc_o, mdio_oe_o}, 32'b010);
                chk(err_o === exp_err, rd ? (present ? "R6" : "R7") : "R9",
                    {name, " error flag"}, 32'(err_o), 32'(exp_err));
                chk(rd_data_o === exp_rd, rd ? (present ? "R8" : "R7") : "R9",
                    {name, " read data"}, 32'(rd_data_o), 32'(exp_rd));
            end
        end
        if (bad != 0)
            $display("  %s first mismatch at clock %0d of frame", name, first_k);
        chk(bad == 0, rd ? "R2 R3 R4 R5 R6" : "R2 R3 R4 R5 R9",
            {name, " per-clock waveform"}, bad_act, bad_exp);
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done_o !== 1'b0 || busy_o !== 1'b0 || mdc_o !== 1'b1) bad++;
        end
        chk(bad == 0, poke ? "R11" : "R10", {name, " quiet after done"}, 32'(bad), 32'd0);
        if (rd) last_rd = exp_rd;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // reset state (R1, R10)
        chk(mdc_o === 1'b1, "R1", "reset mdc high", 32'(mdc_o), 32'd1);
        chk(mdio_oe_o === 1'b0, "R1", "reset line released", 32'(mdio_oe_o), 32'd0);
        chk(busy_o === 1'b0, "R1", "reset not busy", 32'(busy_o), 32'd0);
        chk(done_o === 1'b0, "R10", "reset no done", 32'(done_o), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        run_txn(1'b0, 5'h01, 5'h00, 16'hA55A, 1'b0, 16'h0000, 1'b0, "write_a");
        run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'h3C96, 1'b0, "read_present");
        run_txn(1'b1, 5'h05, 5'h02, 16'h0000, 1'b0, 16'h0000, 1'b0, "read_absent");
        run_txn(1'b1, 5'h00, 5'h15, 16'h0000, 1'b1, 16'h8001, 1'b0, "read_after_absent");
        run_txn(1'b0, 5'h10, 5'h11, 16'h0001, 1'b0, 16'h0000, 1'b1, "write_poked");
        run_txn(1'b1, 5'h0A, 5'h0B, 16'h0000, 1'b1, 16'hFFFF, 1'b1, "read_poked_ones");
        run_txn(1'b0, 5'h1E, 5'h01, 16'hFFFF, 1'b0, 16'h0000, 1'b0, "write_ones");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule